// File: doc/BRIEF.md
# Buffered 16-bit PWM Pulse Generator

This block produces a single pulse-width-modulated output from a 16-bit down-counter. Software-side logic writes a period value and a high-time (duty) value into two buffer registers through a byte-wide write path. Each buffer takes either an upper byte followed by a lower byte, or one full-width write. The counter and the output comparator never read the buffers directly. They work from working copies, which are refreshed only when the counter reloads. A half-finished byte pair is never picked up.

The output is high while the counter value is at or below the working duty, which gives exactly `duty` high ticks in each period. Three duty settings force a fixed level instead: zero, equal to the period, and above the period. A polarity input inverts the pin. While disabled, the pin rests at its inactive level. Raising the enable input loads the buffers straight away and starts counting.

Top module: `pwm16_buf`

## Requirements
- R1: After reset, the period and duty buffers and the working copies all hold 0xFFFF. The counter is 0, and `pwm_out` equals `pol_inv`.
- R2: `wr_mode` selects the write type: 0 writes `wr_data[7:0]` into the upper byte, 1 writes `wr_data[7:0]` into the lower byte, 2 writes all 16 bits of `wr_data`, and 3 is ignored. `wr_target` selects the buffer: 0 is the period buffer and 1 is the duty buffer.
- R3: While running, each cycle with `tick` high lowers the counter by one. When a tick arrives with the counter at 1 or below, the counter reloads with the period. Cycles without a tick leave it unchanged, and the counter never exceeds the working period.
- R4: The working period and working duty change only on a load. A buffer write made in the middle of a period does not alter the current output.
- R5: Each buffer has a pending flag. An upper-byte write sets it, and a lower-byte or full write clears it. While the flag is set, a load keeps the old working value for that buffer.
- R6: When the duty is between 1 and the period minus 1, the raw output is high while the counter is at or below the duty. With a tick on every cycle, a full period therefore shows exactly `duty` high cycles.
- R7: A working duty of 0 gives a constant low raw output.
- R8: A working duty equal to a nonzero working period gives a constant high raw output.
- R9: A working duty greater than the working period gives a constant low raw output.
- R10: When `pol_inv` is 1, `pwm_out` is the inverse of the raw output. While the block is not running, `pwm_out` equals `pol_inv`, so the inactive level is low for normal polarity and high for inverted polarity.
- R11: On the first clock edge with `enable` high after it was low, the block loads the buffers, starts running, and sets the counter to the new period. Any tick in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; a rising level forces a load |
| tick | input | 1 | Count strobe |
| wr_en | input | 1 | Buffer write strobe |
| wr_target | input | 1 | 0 = period buffer, 1 = duty buffer |
| wr_mode | input | 2 | 0 upper byte, 1 lower byte, 2 full word, 3 none |
| wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| pol_inv | input | 1 | Output polarity invert |
| pwm_out | output | 1 | Pulse output |
| cnt_out | output | 16 | Current counter value |

## Verification
The hardest case to reach is a counter reload that falls between the upper-byte and lower-byte writes of a pair. The stimulus leaves a lone upper-byte write in place, with a value that would clearly change the output, and keeps the tick running until the counter wraps. It then counts the high cycles over a whole period to show that the old duty stayed in force. A lower-byte write follows, and the next period shows that the completed pair is then taken up. A tick-free stretch after enable shows the counter holding, and mid-period word writes show the working values holding until the next load.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        WM_HI   = 2'd0,
        WM_LO   = 2'd1,
        WM_WORD = 2'd2,
        WM_NONE = 2'd3
    } wr_mode_e;

    typedef enum logic [1:0] {
        LVL_CMP  = 2'd0,
        LVL_LOW  = 2'd1,
        LVL_HIGH = 2'd2
    } level_e;

    localparam int BUF_PER  = 0;
    localparam int BUF_DUTY = 1;
    localparam int NUM_BUF  = 2;

endpackage

// File: rtl/pwm_byte_buf.sv
module pwm_byte_buf
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  wr_mode_e     mode,
    input  logic [W-1:0] data,
    output logic [W-1:0] value,
    output logic         pend
);
    localparam int LO_W = W / 2;
    localparam int HI_W = W - LO_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '1;
            pend  <= 1'b0;
        end else if (wr_hit) begin
            case (mode)
                WM_HI: begin
                    value[W-1:LO_W] <= data[HI_W-1:0];
                    pend            <= 1'b1;
                end
                WM_LO: begin
                    value[LO_W-1:0] <= data[LO_W-1:0];
                    pend            <= 1'b0;
                end
                WM_WORD: begin
                    value <= data;
                    pend  <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pwm_core_cnt.sv
module pwm_core_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         tick,
    input  logic [W-1:0] buf_per,
    input  logic [W-1:0] buf_duty,
    input  logic         per_ok,
    input  logic         duty_ok,
    output logic [W-1:0] cnt,
    output logic [W-1:0] work_per,
    output logic [W-1:0] work_duty,
    output logic         run
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         start;
    logic         step;
    logic         wrap;
    logic         load;
    logic [W-1:0] next_per;

    assign start    = enable && !run;
    assign step     = run && enable && tick;
    assign wrap     = step && (cnt <= ONE);
    assign load     = start || wrap;
    assign next_per = per_ok ? buf_per : work_per;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            cnt       <= '0;
            work_per  <= '1;
            work_duty <= '1;
        end else begin
            run <= enable;
            if (load) begin
                work_per <= next_per;
                cnt      <= next_per;
                if (duty_ok) begin
                    work_duty <= buf_duty;
                end
            end else if (step) begin
                cnt <= cnt - ONE;
            end
        end
    end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] work_per,
    input  logic [W-1:0] work_duty,
    input  logic         pol_inv,
    output logic         pwm_out
);
    level_e lvl;
    logic   raw;

    always_comb begin
        if (work_duty == '0) begin
            lvl = LVL_LOW;
        end else if (work_duty > work_per) begin
            lvl = LVL_LOW;
        end else if (work_duty == work_per) begin
            lvl = LVL_HIGH;
        end else begin
            lvl = LVL_CMP;
        end

        case (lvl)
            LVL_LOW:  raw = 1'b0;
            LVL_HIGH: raw = 1'b1;
            default:  raw = (cnt <= work_duty);
        endcase

        pwm_out = run ? (raw ^ pol_inv) : pol_inv;
    end
endmodule

// File: rtl/pwm16_buf.sv
module pwm16_buf
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_target,
    input  logic [1:0]       wr_mode,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             pol_inv,
    output logic             pwm_out,
    output logic [CNT_W-1:0] cnt_out
);
    logic [CNT_W-1:0] buf_val  [NUM_BUF];
    logic             buf_pend [NUM_BUF];
    logic [CNT_W-1:0] work_per;
    logic [CNT_W-1:0] work_duty;
    logic             run;
    wr_mode_e         mode;

    assign mode = wr_mode_e'(wr_mode);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        pwm_byte_buf #(.W(CNT_W)) u_buf (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (wr_en && (int'(wr_target) == g)),
            .mode   (mode),
            .data   (wr_data),
            .value  (buf_val[g]),
            .pend   (buf_pend[g])
        );
    end

    pwm_core_cnt #(.W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .tick      (tick),
        .buf_per   (buf_val[BUF_PER]),
        .buf_duty  (buf_val[BUF_DUTY]),
        .per_ok    (!buf_pend[BUF_PER]),
        .duty_ok   (!buf_pend[BUF_DUTY]),
        .cnt       (cnt_out),
        .work_per  (work_per),
        .work_duty (work_duty),
        .run       (run)
    );

    pwm_out_stage #(.W(CNT_W)) u_out (
        .run       (run),
        .cnt       (cnt_out),
        .work_per  (work_per),
        .work_duty (work_duty),
        .pol_inv   (pol_inv),
        .pwm_out   (pwm_out)
    );
endmodule

// File: rtl/pwm16_buf_chk.sv
module pwm16_buf_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         enable,
    input logic         tick,
    input logic         pol_inv,
    input logic         pwm_out,
    input logic [W-1:0] cnt_out,
    input logic [W-1:0] work_per,
    input logic [W-1:0] work_duty,
    input logic         run
);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_out <= work_per);

    p_hold_work_r4: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> ($stable(work_duty) && $stable(work_per)));

    p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
        (run && work_duty == '0) |-> (pwm_out == pol_inv));

    p_equal_high_r8: assert property (@(posedge clk) disable iff (rst)
        (run && work_duty != '0 && work_duty == work_per) |-> (pwm_out != pol_inv));

    p_over_low_r9: assert property (@(posedge clk) disable iff (rst)
        (run && work_duty > work_per) |-> (pwm_out == pol_inv));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == pol_inv));

    p_start_load_r11: assert property (@(posedge clk) disable iff (rst)
        (enable && !run) |=> (run && cnt_out == work_per));
endmodule

bind pwm16_buf pwm16_buf_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .tick      (tick),
    .pol_inv   (pol_inv),
    .pwm_out   (pwm_out),
    .cnt_out   (cnt_out),
    .work_per  (work_per),
    .work_duty (work_duty),
    .run       (run)
);

// File: tb/pwm16_buf_tb.sv
`timescale 1ns/1ps
module pwm16_buf_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_target = 1'b0;
    logic [1:0]  wr_mode = 2'd3;
    logic [15:0] wr_data = '0;
    logic        pol_inv = 1'b0;
    logic        pwm_out;
    logic [15:0] cnt_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string scen = "R1 reset";

    always #2 clk = ~clk;

    pwm16_buf u_dut (
        .clk(clk), .rst(rst), .enable(enable), .tick(tick),
        .wr_en(wr_en), .wr_target(wr_target), .wr_mode(wr_mode),
        .wr_data(wr_data), .pol_inv(pol_inv),
        .pwm_out(pwm_out), .cnt_out(cnt_out)
    );

    // reference model built from the requirements
    logic [15:0] m_buf [2];
    bit          m_pend [2];
    logic [15:0] m_wp, m_wd, m_cnt, m_np;
    bit          m_run, m_start, m_wrap;
    bit          q_out [$];
    logic [15:0] q_cnt [$];
    int          q_tag [$];

    function automatic int cls(bit run, logic [15:0] wp, logic [15:0] wd);
        if (!run) return 10;
        if (wd == 0) return 7;
        if (wd > wp) return 9;
        if (wd == wp) return 8;
        return 6;
    endfunction

    function automatic bit exp_out(bit run, logic [15:0] c, logic [15:0] wp,
                                   logic [15:0] wd, bit pol);
        bit raw;
        if (!run) return pol;
        if (wd == 0 || wd > wp) raw = 1'b0;
        else if (wd == wp) raw = 1'b1;
        else raw = (c <= wd);
        return raw ^ pol;
    endfunction

    function automatic string tagname(int t);
        case (t)
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_buf[0] = '1; m_buf[1] = '1;
            m_pend[0] = 0; m_pend[1] = 0;
            m_wp = '1; m_wd = '1; m_cnt = '0; m_run = 0;
        end else begin
            m_start = enable && !m_run;
            m_wrap  = m_run && enable && tick && (m_cnt <= 16'd1);
            if (m_start || m_wrap) begin
                m_np = m_pend[0] ? m_wp : m_buf[0];
                if (!m_pend[1]) m_wd = m_buf[1];
                m_wp  = m_np;
                m_cnt = m_np;
            end else if (m_run && enable && tick) begin
                m_cnt = m_cnt - 16'd1;
            end
            m_run = enable;
            if (wr_en) begin
                case (wr_mode)
                    2'd0: begin m_buf[wr_target][15:8] = wr_data[7:0]; m_pend[wr_target] = 1; end
                    2'd1: begin m_buf[wr_target][7:0]  = wr_data[7:0]; m_pend[wr_target] = 0; end
                    2'd2: begin m_buf[wr_target] = wr_data; m_pend[wr_target] = 0; end
                    default: ;
                endcase
            end
        end
        q_out.push_back(exp_out(m_run, m_cnt, m_wp, m_wd, pol_inv));
        q_cnt.push_back(m_cnt);
        q_tag.push_back(cls(m_run, m_wp, m_wd));
    end

    // monitor: compares after each edge has settled
    always @(posedge clk) begin
        #1;
        while (q_out.size() > 0) begin
            bit          eo;
            logic [15:0] ec;
            int          et;
            eo = q_out.pop_front();
            ec = q_cnt.pop_front();
            et = q_tag.pop_front();
            checks++;
            if (pwm_out !== eo) begin
                errors++;
                $display("FAIL %s [%s] pwm_out act=%b exp=%b t=%0t",
                         tagname(et), scen, pwm_out, eo, $time);
            end
            checks++;
            if (cnt_out !== ec) begin
                errors++;
                $display("FAIL R3 [%s] cnt_out act=%0d exp=%0d t=%0t",
                         scen, cnt_out, ec, $time);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(bit tgt, logic [1:0] m, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_target = tgt; wr_mode = m; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_mode = 2'd3;
    endtask

    task automatic restart();
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
    endtask

    task automatic count_high(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            c += int'(pwm_out);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act=running exp=done");
            finish_run();
        end
    end

    initial begin
        int c;
        idle(3);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(pwm_out == 1'b0, "R1 output idle after reset", pwm_out, 0);
        chk(cnt_out == 16'd0, "R1 counter after reset", cnt_out, 0);

        scen = "R11 start with reset buffers";
        @(negedge clk); enable = 1'b1; tick = 1'b1;
        @(posedge clk); #1;
        chk(cnt_out == 16'hFFFF, "R11 load of reset period", cnt_out, 16'hFFFF);
        chk(pwm_out == 1'b1, "R8 reset duty equals reset period", pwm_out, 1);

        scen = "R6 word writes";
        wr(0, 2'd2, 16'd10);
        wr(1, 2'd2, 16'd3);
        restart();
        count_high(10, c);
        chk(c == 3, "R6 high cycles per period", c, 3);

        scen = "R4 mid-period write";
        idle(4);
        wr(1, 2'd2, 16'd6);
        idle(12);
        count_high(10, c);
        chk(c == 6, "R4 new duty after reload", c, 6);

        scen = "R2 byte pair";
        wr(1, 2'd0, 16'h0000);
        wr(1, 2'd1, 16'h0005);
        wr(1, 2'd3, 16'h0009);
        restart();
        count_high(10, c);
        chk(c == 5, "R2 byte pair duty, mode 3 ignored", c, 5);

        scen = "R5 pending upper";
        wr(1, 2'd0, 16'h0001);
        idle(12);
        count_high(10, c);
        chk(c == 5, "R5 incomplete pair not transferred", c, 5);
        wr(1, 2'd1, 16'h0007);
        idle(12);
        count_high(10, c);
        chk(c == 0, "R9 duty above period after pair done", c, 0);

        scen = "R7 zero duty";
        wr(1, 2'd2, 16'd0);
        restart();
        count_high(10, c);
        chk(c == 0, "R7 zero duty stays low", c, 0);

        scen = "R8 duty equals period";
        wr(1, 2'd2, 16'd10);
        restart();
        count_high(10, c);
        chk(c == 10, "R8 equal duty stays high", c, 10);

        scen = "R3 tick gaps";
        wr(1, 2'd2, 16'd4);
        @(negedge clk); tick = 1'b0;
        restart();
        @(posedge clk); #1;
        chk(cnt_out == 16'd10, "R3 counter after start", cnt_out, 10);
        idle(3);
        chk(cnt_out == 16'd10, "R3 counter holds without tick", cnt_out, 10);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        chk(cnt_out == 16'd9, "R3 single tick decrements", cnt_out, 9);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); tick = (i % 3) != 0;
        end
        @(negedge clk); tick = 1'b1;

        scen = "R10 polarity";
        @(negedge clk); pol_inv = 1'b1; enable = 1'b0;
        @(posedge clk); #1;
        chk(pwm_out == 1'b1, "R10 inverted idle level", pwm_out, 1);
        wr(1, 2'd2, 16'd3);
        @(negedge clk); enable = 1'b1;
        count_high(10, c);
        chk(c == 7, "R10 inverted output high cycles", c, 7);
        @(negedge clk); enable = 1'b0; pol_inv = 1'b0;
        @(posedge clk); #1;
        chk(pwm_out == 1'b0, "R10 normal idle level", pwm_out, 0);

        idle(4);
        done = 1'b1;
        finish_run();
    end
endmodule